// File: doc/BRIEF.md
# ADC Conversion Sequencer with Threshold Interrupt

This block is the digital controller for a multi-channel successive-approximation converter. Software writes four small registers through a write-strobe port. One sets the power, run, reference-range and conversion-time fields. One selects the channel. One configures the threshold compare. One holds the 10-bit threshold. When run is set, the block starts the analog core with a one-cycle start pulse. It passes the channel and the conversion length in clocks, waits for the core's done strobe, copies the returned sample into the result register and starts the next conversion at once. Conversions continue back to back until run is cleared.

A warm-up counter measures how long the converter has been powered. A conversion whose lifetime overlaps any cycle before warm-up expiry is marked invalid, and its interrupt is withheld. Writing the channel register while running abandons the conversion in flight and starts a fresh one on the new channel. In threshold mode, an interrupt is raised only for valid results that meet the selected condition against the threshold. Otherwise every valid result raises one.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is held, the outputs `result`, `result_valid`, `irq` and `conv_start` are all 0.
- R2: A write to address 0 that sets bit 1 (run) while run was clear raises `conv_start` for one cycle. The pulse comes in the cycle after the write. With it, `conv_chan` equals the channel register (address 1, bits 2:0), and `conv_len` equals table entry number bits 5:3 of address 0. The default entries for codes 0..7 are 6, 8, 10, 12, 16, 20, 24 and 32 clocks.
- R3: While running, a done strobe from the core copies `conv_data` into `result` in the next cycle. In that same cycle a new `conv_start` is issued.
- R4: With threshold mode off, every valid result produces a one-cycle `irq` pulse in the same cycle that `result` updates.
- R5: Warm-up counts clocks while bit 0 of address 0 (power) is set. The limit is WARM_NORM clocks, or WARM_HI clocks when bit 2 (high reference) is set. A conversion that overlaps any cycle before expiry still updates `result`, but `result_valid` is 0 and no `irq` is given.
- R6: Clearing power resets the warm-up count. After power is set again, the next results are invalid until the full interval has elapsed again.
- R7: A write to address 1 while running abandons the conversion in flight. A done strobe in the write cycle, or in the cycle that immediately follows it, is ignored. A new start on the new channel is issued in the cycle after the write, so the core's done arrives `conv_len`+2 cycles after the write cycle.
- R8: Bit 0 of address 2 enables threshold mode. Bit 1 selects the condition: 0 means result ≥ threshold, 1 means result < threshold (unsigned). The threshold sits at address 3, bits 9:0. In this mode, a valid result raises `irq` only when the condition holds.
- R9: Clearing run stops further starts. A done strobe arriving after the stop leaves `result` unchanged and raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 10 | Register write data |
| conv_start | output | 1 | One-cycle start pulse to the analog core |
| conv_chan | output | 3 | Channel for the conversion being started |
| conv_len | output | 8 | Conversion length in clocks for the core |
| conv_done | input | 1 | Core completion strobe |
| conv_data | input | 10 | Sample returned with the done strobe |
| result | output | 10 | Last captured sample |
| result_valid | output | 1 | Last captured sample was taken fully warmed up |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The delicate coincidence is a channel write landing in the very cycle that the core reports completion. In that cycle the block must drop the finished sample and start over on the new channel, not capture and then launch twice. The bench waits for the negative edge where done is visible and drives the channel write in that same cycle. It then judges that `result` holds its previous value, that no interrupt appears, and that the next start carries the new channel. A second overlap, a stale done in the cycle right after a restart, arises naturally in the randomized phase. There the bench checks the exact restart latency of `conv_len`+2 cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W   = 10;
    localparam int CHAN_W   = 3;
    localparam int TSEL_W   = 3;
    localparam int ADDR_W   = 2;
    localparam int NUM_TSEL = 1 << TSEL_W;

    // Register addresses
    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_CHAN = 2'd1,
        A_PF   = 2'd2,
        A_THR  = 2'd3
    } reg_addr_e;

    // Field positions inside the control and compare registers
    localparam int CTL_PWR   = 0;
    localparam int CTL_RUN   = 1;
    localparam int CTL_HIREF = 2;
    localparam int CTL_TSEL  = 3;
    localparam int PF_EN     = 0;
    localparam int PF_BELOW  = 1;

    typedef struct packed {
        logic              pwr;
        logic              run;
        logic              hiref;
        logic [TSEL_W-1:0] tsel;
        logic [CHAN_W-1:0] chan;
        logic              pf_en;
        logic              pf_below;
        logic [DATA_W-1:0] thr;
    } cfg_t;

    // Interrupt qualification for a valid sample
    function automatic logic pf_pass(input logic en, input logic below,
                                     input logic [DATA_W-1:0] smp,
                                     input logic [DATA_W-1:0] lim);
        logic hit;
        hit = below ? (smp < lim) : (smp >= lim);
        return !en || hit;
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_q,
    output cfg_t              cfg_d,
    output logic              ev_run_on,
    output logic              ev_run_off,
    output logic              ev_chan
);

    always_comb begin
        cfg_d      = cfg_q;
        ev_run_on  = 1'b0;
        ev_run_off = 1'b0;
        ev_chan    = 1'b0;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_CTRL: begin
                    cfg_d.pwr   = wr_data[CTL_PWR];
                    cfg_d.run   = wr_data[CTL_RUN];
                    cfg_d.hiref = wr_data[CTL_HIREF];
                    cfg_d.tsel  = wr_data[CTL_TSEL +: TSEL_W];
                    ev_run_on   = wr_data[CTL_RUN] && !cfg_q.run;
                    ev_run_off  = !wr_data[CTL_RUN] && cfg_q.run;
                end
                A_CHAN: begin
                    cfg_d.chan = wr_data[CHAN_W-1:0];
                    ev_chan    = 1'b1;
                end
                A_PF: begin
                    cfg_d.pf_en    = wr_data[PF_EN];
                    cfg_d.pf_below = wr_data[PF_BELOW];
                end
                A_THR: begin
                    cfg_d.thr = wr_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/adc_seq_warmup.sv
module adc_seq_warmup #(
    parameter int WARM_NORM = 850,
    parameter int WARM_HI   = 700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    input  logic hiref,
    output logic warm_done
);

    localparam int WMAX = (WARM_NORM > WARM_HI) ? WARM_NORM : WARM_HI;
    localparam int CW   = $clog2(WMAX + 1);
    localparam logic [CW-1:0] LIM_NORM = CW'(WARM_NORM);
    localparam logic [CW-1:0] LIM_HI   = CW'(WARM_HI);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = hiref ? LIM_HI : LIM_NORM;
        cnt_d = cnt_q;
        if (!pwr) begin
            cnt_d = '0;
        end else if (cnt_q < limit) begin
            cnt_d = cnt_q + 1'b1;
        end
        warm_done = pwr && (cnt_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
    import adc_seq_pkg::*;
#(
    parameter int                     LEN_W      = 8,
    parameter logic [8*LEN_W-1:0]     CONV_TABLE = {8'd32, 8'd24, 8'd20, 8'd16,
                                                    8'd12, 8'd10, 8'd8,  8'd6}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg_q,
    input  cfg_t              cfg_d,
    input  logic              ev_run_on,
    input  logic              ev_run_off,
    input  logic              ev_chan,
    input  logic              warm_done,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [LEN_W-1:0]  conv_len,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              irq
);

    typedef struct packed {
        logic              active;
        logic              start;
        logic [CHAN_W-1:0] chan;
        logic [LEN_W-1:0]  len;
        logic              cold;
        logic [DATA_W-1:0] result;
        logic              valid;
        logic              irq;
    } seq_t;

    seq_t seq_d, seq_q;

    logic chan_restart;
    logic done_ok;
    logic launch;
    logic smp_valid;

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        seq_d.irq   = 1'b0;

        // A channel write while running abandons the conversion in flight
        chan_restart = ev_chan && cfg_q.run && seq_q.active;
        // Completion is honoured only for a live conversion, not in the cycle
        // a new one is issued, and not when a restart or stop collides with it
        done_ok = seq_q.active && conv_done && !seq_q.start &&
                  !ev_chan && !ev_run_off;
        launch  = ev_run_on || chan_restart || done_ok;

        smp_valid = !seq_q.cold && warm_done;

        if (done_ok) begin
            seq_d.result = conv_data;
            seq_d.valid  = smp_valid;
            seq_d.irq    = smp_valid &&
                           pf_pass(cfg_q.pf_en, cfg_q.pf_below, conv_data, cfg_q.thr);
        end

        if (launch) begin
            seq_d.active = 1'b1;
            seq_d.start  = 1'b1;
            seq_d.chan   = cfg_d.chan;
            seq_d.len    = CONV_TABLE[cfg_d.tsel*LEN_W +: LEN_W];
            seq_d.cold   = !warm_done;
        end else begin
            seq_d.cold   = seq_q.cold || !warm_done;
        end

        if (ev_run_off) begin
            seq_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_start   = seq_q.start;
    assign conv_chan    = seq_q.chan;
    assign conv_len     = seq_q.len;
    assign result       = seq_q.result;
    assign result_valid = seq_q.valid;
    assign irq          = seq_q.irq;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int                 LEN_W      = 8,
    parameter logic [8*LEN_W-1:0] CONV_TABLE = {8'd32, 8'd24, 8'd20, 8'd16,
                                                8'd12, 8'd10, 8'd8,  8'd6},
    parameter int                 WARM_NORM  = 850,
    parameter int                 WARM_HI    = 700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [LEN_W-1:0]  conv_len,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              irq
);

    cfg_t cfg_q;
    cfg_t cfg_d;
    logic ev_run_on;
    logic ev_run_off;
    logic ev_chan;
    logic warm_done;

    adc_seq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cfg_q      (cfg_q),
        .cfg_d      (cfg_d),
        .ev_run_on  (ev_run_on),
        .ev_run_off (ev_run_off),
        .ev_chan    (ev_chan)
    );

    adc_seq_warmup #(
        .WARM_NORM (WARM_NORM),
        .WARM_HI   (WARM_HI)
    ) u_warm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr       (cfg_q.pwr),
        .hiref     (cfg_q.hiref),
        .warm_done (warm_done)
    );

    adc_seq_engine #(
        .LEN_W      (LEN_W),
        .CONV_TABLE (CONV_TABLE)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_q        (cfg_q),
        .cfg_d        (cfg_d),
        .ev_run_on    (ev_run_on),
        .ev_run_off   (ev_run_off),
        .ev_chan      (ev_chan),
        .warm_done    (warm_done),
        .conv_done    (conv_done),
        .conv_data    (conv_data),
        .conv_start   (conv_start),
        .conv_chan    (conv_chan),
        .conv_len     (conv_len),
        .result       (result),
        .result_valid (result_valid),
        .irq          (irq)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              run_q,
    input logic              pf_en,
    input logic              pf_below,
    input logic [DATA_W-1:0] thr,
    input logic              warm_done,
    input logic              conv_start,
    input logic [DATA_W-1:0] result,
    input logic              result_valid,
    input logic              irq
);

    // R4: the interrupt is a single-cycle pulse
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: an interrupt only accompanies a valid result
    p_irq_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> result_valid);

    // R5: the capture behind an interrupt happened with warm-up expired
    p_irq_warm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(warm_done));

    // R2: a start is only issued with run set
    p_start_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> run_q);

    // R9: with run clear and no write, no start follows
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_en) |=> !conv_start);

    // R8: at-or-above condition holds for every interrupt in that mode
    p_pf_above_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && pf_en && !pf_below && !$past(wr_en)) |-> (result >= thr));

    // R8: below condition holds for every interrupt in that mode
    p_pf_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && pf_en && pf_below && !$past(wr_en)) |-> (result < thr));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .run_q        (cfg_q.run),
    .pf_en        (cfg_q.pf_en),
    .pf_below     (cfg_q.pf_below),
    .thr          (cfg_q.thr),
    .warm_done    (warm_done),
    .conv_start   (conv_start),
    .result       (result),
    .result_valid (result_valid),
    .irq          (irq)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    import adc_seq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              conv_start;
    logic [CHAN_W-1:0] conv_chan;
    logic [7:0]        conv_len;
    logic              conv_done;
    logic [DATA_W-1:0] conv_data;
    logic [DATA_W-1:0] result;
    logic              result_valid;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_len(conv_len),
        .conv_done(conv_done), .conv_data(conv_data),
        .result(result), .result_valid(result_valid), .irq(irq)
    );

    // Behavioural analog core: a start restarts it, done follows after len clocks
    int                core_cnt;
    logic [CHAN_W-1:0] core_chan;
    logic              force_en;
    logic [DATA_W-1:0] force_val;

    always @(posedge clk) begin
        if (!rst_n) begin
            core_cnt  <= 0;
            conv_done <= 1'b0;
            conv_data <= '0;
            core_chan <= '0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start) begin
                core_cnt  <= int'(conv_len);
                core_chan <= conv_chan;
            end else if (core_cnt != 0) begin
                core_cnt <= core_cnt - 1;
                if (core_cnt == 1) begin
                    conv_done <= 1'b1;
                    conv_data <= force_en ? force_val : DATA_W'($urandom);
                end
            end
        end
    end

    function automatic int lentab(input int code);
        case (code)
            0: return 6;   1: return 8;   2: return 10;  3: return 12;
            4: return 16;  5: return 20;  6: return 24;  default: return 32;
        endcase
    endfunction

    function automatic logic exp_irq(input logic en, input logic below,
                                     input int d, input int t);
        if (!en) return 1'b1;
        return below ? (d < t) : (d >= t);
    endfunction

    function automatic logic [DATA_W-1:0] ctl(input logic pwr, input logic run,
                                              input logic hi, input int ts);
        logic [DATA_W-1:0] v;
        v = '0;
        v[0] = pwr; v[1] = run; v[2] = hi; v[5:3] = 3'(ts);
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Caller stands at a negative edge; write spans the next rising edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 1;
        do begin
            @(negedge clk);
            n++;
        end while (!conv_done && n < 5000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int d;
        int prev;
        logic seen;
        void'($urandom(2024));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        force_en = 1'b0; force_val = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(result == 0,       "R1 result", int'(result), 0);
        chk(result_valid == 0, "R1 valid", int'(result_valid), 0);
        chk(irq == 0,          "R1 irq", int'(irq), 0);
        chk(conv_start == 0,   "R1 start", int'(conv_start), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R5: start without warm-up
        wr(A_CHAN, 10'd5);
        wr(A_CTRL, ctl(1, 1, 0, 0));
        chk(conv_start == 1,  "R2 start", int'(conv_start), 1);
        chk(conv_chan == 5,   "R2 chan", int'(conv_chan), 5);
        chk(conv_len == 6,    "R2 len", int'(conv_len), 6);
        wait_done(n);
        d = int'(conv_data);
        @(negedge clk);
        chk(result == DATA_W'(d), "R5 cold result", int'(result), d);
        chk(result_valid == 0,    "R5 cold valid", int'(result_valid), 0);
        chk(irq == 0,             "R5 cold irq", int'(irq), 0);

        // R3 / R4: after warm-up, back-to-back valid results
        repeat (900) @(negedge clk);
        wait_done(n);
        d = int'(conv_data);
        @(negedge clk);
        chk(result == DATA_W'(d), "R3 capture", int'(result), d);
        chk(conv_start == 1,      "R3 relaunch", int'(conv_start), 1);
        chk(result_valid == 1,    "R4 valid", int'(result_valid), 1);
        chk(irq == 1,             "R4 irq", int'(irq), 1);

        // R6: dropping power restarts the warm-up
        wr(A_CTRL, ctl(0, 1, 0, 0));
        repeat (3) @(negedge clk);
        wait_done(n);
        @(negedge clk);
        chk(result_valid == 0, "R6 unpowered valid", int'(result_valid), 0);
        wr(A_CTRL, ctl(1, 1, 1, 1));
        wait_done(n);
        @(negedge clk);
        chk(result_valid == 0, "R6 repowered valid", int'(result_valid), 0);

        // R5: high reference uses the shorter interval
        wr(A_CTRL, ctl(0, 0, 1, 0));
        repeat (20) @(negedge clk);
        wr(A_CTRL, ctl(1, 0, 1, 0));
        repeat (715) @(negedge clk);
        wr(A_CTRL, ctl(1, 1, 1, 2));
        chk(conv_len == 10, "R2 len code2", int'(conv_len), 10);
        wait_done(n);
        @(negedge clk);
        chk(result_valid == 1, "R5 hiref valid", int'(result_valid), 1);
        chk(irq == 1,          "R5 hiref irq", int'(irq), 1);

        // R7 / R8 / R2: randomized configurations with restart timing
        for (int it = 0; it < 24; it++) begin
            int ts, ch, thr;
            logic pfen, below;
            ts    = int'($urandom % 8);
            ch    = int'($urandom % 8);
            pfen  = (it >= 4) ? 1'($urandom % 2) : 1'b0;
            below = 1'($urandom % 2);
            thr   = int'($urandom % 1024);
            force_en  = (it % 6 == 5);
            force_val = DATA_W'(thr);
            wr(A_CTRL, ctl(1, 1, 1, ts));
            wr(A_PF, {8'd0, below, pfen});
            wr(A_THR, DATA_W'(thr));
            wr(A_CHAN, DATA_W'(ch));
            chk(conv_start == 1,                "R7 restart", int'(conv_start), 1);
            chk(conv_chan == CHAN_W'(ch),       "R7 chan", int'(conv_chan), ch);
            chk(int'(conv_len) == lentab(ts),   "R2 len", int'(conv_len), lentab(ts));
            wait_done(n);
            chk(n == lentab(ts) + 2,            "R7 latency", n, lentab(ts) + 2);
            chk(core_chan == CHAN_W'(ch),       "R7 core chan", int'(core_chan), ch);
            d = int'(conv_data);
            @(negedge clk);
            chk(result == DATA_W'(d),           "R3 result", int'(result), d);
            chk(result_valid == 1,              "R4 valid", int'(result_valid), 1);
            chk(irq == exp_irq(pfen, below, d, thr), "R8 irq",
                int'(irq), int'(exp_irq(pfen, below, d, thr)));
        end
        force_en = 1'b0;

        // R7 corner: channel write in the same cycle as completion
        wr(A_PF, 10'd0);
        wait_done(n);
        prev = int'(result);
        wr(A_CHAN, 10'd3);
        chk(result == DATA_W'(prev), "R7 dropped result", int'(result), prev);
        chk(irq == 0,                "R7 dropped irq", int'(irq), 0);
        chk(conv_start == 1,         "R7 coincident restart", int'(conv_start), 1);
        chk(conv_chan == 3,          "R7 coincident chan", int'(conv_chan), 3);
        wait_done(n);
        d = int'(conv_data);
        @(negedge clk);
        chk(result == DATA_W'(d),    "R7 new result", int'(result), d);
        chk(core_chan == 3,          "R7 new core chan", int'(core_chan), 3);

        // R9: stop with a conversion in flight
        repeat (3) @(negedge clk);
        wr(A_CTRL, ctl(1, 0, 1, 7));
        prev = int'(result);
        seen = 1'b0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (conv_start || irq) seen = 1'b1;
        end
        chk(seen == 0,               "R9 quiet", int'(seen), 0);
        chk(result == DATA_W'(prev), "R9 result held", int'(result), prev);
        wr(A_CTRL, ctl(0, 0, 1, 7));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule